// File: doc/BRIEF.md
# Decision Tree Level Stage

This block evaluates one level of a binary decision tree as a single pipeline stage. Each accepted transfer carries a feature vector, the index of the tree being walked and the index of the current node within this level. The stage looks up that node's split parameters (a threshold and a feature selector) in a node store private to this level. It picks the selected feature from the vector, compares it with the threshold and hands the child node index, the tree index and the unchanged feature vector to the next level. A chain of these stages, one per level, walks a whole forest with one sample leaving per cycle.

Flow control is a valid/ready pair on each side. The stage is a two-state machine. ST_IDLE means no result is held. ST_HOLD means a result is presented downstream. The transitions are: ACCEPT (ST_IDLE to ST_HOLD on an input transfer), STREAM (ST_HOLD to ST_HOLD when the held result leaves and a new sample enters in the same cycle), STALL (ST_HOLD to ST_HOLD while downstream is not ready) and DRAIN (ST_HOLD to ST_IDLE when the result leaves and nothing enters). The node store is loaded through a write port that is honoured only in ST_IDLE.

Top module: `dtl_level_stage`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The node entry used for a sample lives at address in_tree * NODES_PER_TREE + in_node, where NODES_PER_TREE = 2^LEVEL. Every (tree, node) pair therefore has its own entry, and writes address entries the same way through wr_tree and wr_node.
- R3: Feature k of a vector occupies bits [k*FEAT_W +: FEAT_W]. The entry's selector picks which feature is compared. A selector of NUM_FEAT or more picks feature 0.
- R4: The comparison is unsigned. A feature strictly above the threshold yields direction bit 1 (right child). A feature equal to or below the threshold yields 0 (left child).
- R5: out_node is LEVEL+1 bits wide and equals {in_node, direction bit}, i.e. the parent index shifted left by one plus the direction bit.
- R6: A sample accepted on a clock edge appears on the outputs right after that edge with out_valid 1, and out_feat and out_tree equal to the accepted in_feat and in_tree.
- R7: While out_valid is 1 and out_ready is 0, in_ready is 0 in the same cycle, and out_feat, out_tree and out_node keep their values on the next cycle.
- R8: With out_ready held at 1, in_ready stays 1, so one sample enters and one leaves on every cycle. When the stage holds nothing, in_ready is 1 whatever out_ready is.
- R9: A write on the write port takes effect only when no result is held (out_valid is 0). A write presented while a result is held is dropped and leaves the entry unchanged.
- R10: If a write and a sample lookup hit the same entry on the same edge, the lookup uses the entry's previous contents and later lookups see the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream sample valid |
| in_ready | output | 1 | Stage can take a sample this cycle |
| in_feat | input | NUM_FEAT*FEAT_W | Feature vector, feature k at bits [k*FEAT_W +: FEAT_W] |
| in_tree | input | TREE_W | Tree index |
| in_node | input | LEVEL | Node index within this level |
| out_valid | output | 1 | Result held for the next level |
| out_ready | input | 1 | Next level takes the result |
| out_feat | output | NUM_FEAT*FEAT_W | Feature vector passed on |
| out_tree | output | TREE_W | Tree index passed on |
| out_node | output | LEVEL+1 | Child node index |
| wr_en | input | 1 | Node store write request |
| wr_tree | input | TREE_W | Tree index of the written entry |
| wr_node | input | LEVEL | Node index of the written entry |
| wr_thresh | input | FEAT_W | Threshold to store |
| wr_sel | input | SEL_W | Feature selector to store |

## Verification
A wrong state bit shows at the ports within one cycle. A stage stuck in ST_HOLD presents a stale result, or keeps in_ready low while downstream is not ready. A stage that falls to ST_IDLE too early drops a held result: out_valid goes low under a stall. A wrong address or read timing shows on the next output as a direction bit that disagrees with the threshold written for that tree and node. Every entry is swept across all feature values, so a single mis-addressed or mis-compared entry flips at least one expected child index.

// File: rtl/dtl_pkg.sv
package dtl_pkg;

    // Occupancy of the single result register of a level stage.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } dtl_state_e;

    // Width helper that never returns zero.
    function automatic int dtl_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/dtl_node_mem.sv
// Read-first synchronous node store: a write and a read of the same
// entry on one edge return the previous contents.
module dtl_node_mem #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 6,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/dtl_node_ctrl.sv
// Address generation, write gating and field packing for one level's
// node store.
module dtl_node_ctrl #(
    parameter int NUM_TREES      = 4,
    parameter int NODES_PER_TREE = 8,
    parameter int TREE_W         = 2,
    parameter int NODE_W         = 3,
    parameter int THR_W          = 16,
    parameter int SEL_W          = 3,
    parameter int AW             = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [TREE_W-1:0] rd_tree,
    input  logic [NODE_W-1:0] rd_node,
    input  logic              wr_req,
    input  logic              wr_allow,
    input  logic [TREE_W-1:0] wr_tree,
    input  logic [NODE_W-1:0] wr_node,
    input  logic [THR_W-1:0]  wr_thr,
    input  logic [SEL_W-1:0]  wr_sel,
    output logic [THR_W-1:0]  rd_thr,
    output logic [SEL_W-1:0]  rd_sel
);

    localparam int DEPTH  = NUM_TREES * NODES_PER_TREE;
    localparam int WORD_W = THR_W + SEL_W;

    logic [AW-1:0]     raddr;
    logic [AW-1:0]     waddr;
    logic              we;
    logic [WORD_W-1:0] wword;
    logic [WORD_W-1:0] rword;

    function automatic logic [AW-1:0] entry_of(input logic [TREE_W-1:0] t,
                                               input logic [NODE_W-1:0] n);
        return AW'(int'(t) * NODES_PER_TREE + int'(n));
    endfunction

    always_comb begin
        raddr = entry_of(rd_tree, rd_node);
        waddr = entry_of(wr_tree, wr_node);
        we    = wr_req && wr_allow;
        wword = {wr_thr, wr_sel};
    end

    dtl_node_mem #(
        .DEPTH (DEPTH),
        .WIDTH (WORD_W),
        .AW    (AW)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (waddr),
        .wdata (wword),
        .re    (rd_en),
        .raddr (raddr),
        .rdata (rword)
    );

    assign rd_thr = rword[WORD_W-1:SEL_W];
    assign rd_sel = rword[SEL_W-1:0];

endmodule

// File: rtl/dtl_split_cmp.sv
// Feature multiplexer, unsigned split compare and child index build.
module dtl_split_cmp #(
    parameter int NUM_FEAT = 8,
    parameter int FEAT_W   = 16,
    parameter int SEL_W    = 3,
    parameter int NODE_W   = 3
) (
    input  logic [NUM_FEAT*FEAT_W-1:0] feat_vec,
    input  logic [SEL_W-1:0]           sel,
    input  logic [FEAT_W-1:0]          thr,
    input  logic [NODE_W-1:0]          parent,
    output logic                       go_right,
    output logic [NODE_W:0]            child
);

    logic [FEAT_W-1:0] feat_a [NUM_FEAT];
    logic [FEAT_W-1:0] picked;

    for (genvar k = 0; k < NUM_FEAT; k++) begin : g_unpack
        assign feat_a[k] = feat_vec[k*FEAT_W +: FEAT_W];
    end

    always_comb begin
        if (int'(sel) < NUM_FEAT) begin
            picked = feat_a[sel];
        end else begin
            picked = feat_a[0];
        end
        go_right = (picked > thr);
        child    = {parent, go_right};
    end

endmodule

// File: rtl/dtl_level_stage.sv
// One level of a pipelined decision tree walk. LEVEL must be at least 1.
module dtl_level_stage
    import dtl_pkg::*;
#(
    parameter int FEAT_W    = 16,
    parameter int NUM_FEAT  = 8,
    parameter int LEVEL     = 3,
    parameter int NUM_TREES = 4,
    parameter int SEL_W     = dtl_bits(NUM_FEAT),
    parameter int TREE_W    = dtl_bits(NUM_TREES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [NUM_FEAT*FEAT_W-1:0] in_feat,
    input  logic [TREE_W-1:0]          in_tree,
    input  logic [LEVEL-1:0]           in_node,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [NUM_FEAT*FEAT_W-1:0] out_feat,
    output logic [TREE_W-1:0]          out_tree,
    output logic [LEVEL:0]             out_node,
    input  logic                       wr_en,
    input  logic [TREE_W-1:0]          wr_tree,
    input  logic [LEVEL-1:0]           wr_node,
    input  logic [FEAT_W-1:0]          wr_thresh,
    input  logic [SEL_W-1:0]           wr_sel
);

    localparam int NODES_PER_TREE = 1 << LEVEL;
    localparam int DEPTH          = NUM_TREES * NODES_PER_TREE;
    localparam int AW             = dtl_bits(DEPTH);
    localparam int VEC_W          = NUM_FEAT * FEAT_W;

    dtl_state_e          state_q;
    dtl_state_e          state_d;
    logic                accept;
    logic                wr_allow;
    logic [VEC_W-1:0]    feat_q;
    logic [TREE_W-1:0]   tree_q;
    logic [LEVEL-1:0]    node_q;
    logic [FEAT_W-1:0]   rd_thr;
    logic [SEL_W-1:0]    rd_sel;
    logic                go_right;
    logic [LEVEL:0]      child;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: ACCEPT, STREAM, STALL, DRAIN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (out_ready && !accept) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State-decoded control.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        wr_allow  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                wr_allow = 1'b1;
            end
            ST_HOLD: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        accept = in_valid && in_ready;
    end

    // Sample payload register, loaded alongside the node store read.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            feat_q <= '0;
            tree_q <= '0;
            node_q <= '0;
        end else if (accept) begin
            feat_q <= in_feat;
            tree_q <= in_tree;
            node_q <= in_node;
        end
    end

    dtl_node_ctrl #(
        .NUM_TREES      (NUM_TREES),
        .NODES_PER_TREE (NODES_PER_TREE),
        .TREE_W         (TREE_W),
        .NODE_W         (LEVEL),
        .THR_W          (FEAT_W),
        .SEL_W          (SEL_W),
        .AW             (AW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (accept),
        .rd_tree  (in_tree),
        .rd_node  (in_node),
        .wr_req   (wr_en),
        .wr_allow (wr_allow),
        .wr_tree  (wr_tree),
        .wr_node  (wr_node),
        .wr_thr   (wr_thresh),
        .wr_sel   (wr_sel),
        .rd_thr   (rd_thr),
        .rd_sel   (rd_sel)
    );

    dtl_split_cmp #(
        .NUM_FEAT (NUM_FEAT),
        .FEAT_W   (FEAT_W),
        .SEL_W    (SEL_W),
        .NODE_W   (LEVEL)
    ) u_cmp (
        .feat_vec (feat_q),
        .sel      (rd_sel),
        .thr      (rd_thr),
        .parent   (node_q),
        .go_right (go_right),
        .child    (child)
    );

    assign out_feat = feat_q;
    assign out_tree = tree_q;
    assign out_node = child;

endmodule

// File: rtl/dtl_level_stage_chk.sv
module dtl_level_stage_chk #(
    parameter int FEAT_W   = 16,
    parameter int NUM_FEAT = 8,
    parameter int LEVEL    = 3,
    parameter int SEL_W    = 3,
    parameter int TREE_W   = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [NUM_FEAT*FEAT_W-1:0] in_feat,
    input logic [TREE_W-1:0]          in_tree,
    input logic [LEVEL-1:0]           in_node,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [NUM_FEAT*FEAT_W-1:0] out_feat,
    input logic [TREE_W-1:0]          out_tree,
    input logic [LEVEL:0]             out_node,
    input logic [FEAT_W-1:0]          rd_thr,
    input logic [SEL_W-1:0]           rd_sel
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!out_valid); // R1
        end
    end

    AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_feat)
            && $stable(out_tree) && $stable(out_node))); // R7

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_feat == $past(in_feat)
            && out_tree == $past(in_tree))); // R6

    AST_CHILD_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_node[LEVEL:1] == $past(in_node))); // R5

    AST_SPLIT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (int'(rd_sel) < NUM_FEAT)) |->
            (out_node[0] == (out_feat[rd_sel*FEAT_W +: FEAT_W] > rd_thr))); // R4

endmodule

bind dtl_level_stage dtl_level_stage_chk #(
    .FEAT_W   (FEAT_W),
    .NUM_FEAT (NUM_FEAT),
    .LEVEL    (LEVEL),
    .SEL_W    (SEL_W),
    .TREE_W   (TREE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_feat   (in_feat),
    .in_tree   (in_tree),
    .in_node   (in_node),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_feat  (out_feat),
    .out_tree  (out_tree),
    .out_node  (out_node),
    .rd_thr    (rd_thr),
    .rd_sel    (rd_sel)
);

// File: tb/tb_dtl_level_stage.sv
module tb_dtl_level_stage;

    localparam int FW = 4;
    localparam int NF = 4;
    localparam int LV = 2;
    localparam int NT = 2;
    localparam int NPT = 1 << LV;
    localparam int ENT = NT * NPT;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [NF*FW-1:0] in_feat = '0;
    logic          in_tree = 1'b0;
    logic [LV-1:0] in_node = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [NF*FW-1:0] out_feat;
    logic          out_tree;
    logic [LV:0]   out_node;
    logic          wr_en = 1'b0;
    logic          wr_tree = 1'b0;
    logic [LV-1:0] wr_node = '0;
    logic [FW-1:0] wr_thresh = '0;
    logic [1:0]    wr_sel = '0;

    int total = 0;
    int bad = 0;
    int m_thr [ENT];
    int m_sel [ENT];

    always #10 clk = ~clk;

    dtl_level_stage #(
        .FEAT_W (FW), .NUM_FEAT (NF), .LEVEL (LV), .NUM_TREES (NT)
    ) dut (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_feat (in_feat),
        .in_tree (in_tree), .in_node (in_node),
        .out_valid (out_valid), .out_ready (out_ready), .out_feat (out_feat),
        .out_tree (out_tree), .out_node (out_node),
        .wr_en (wr_en), .wr_tree (wr_tree), .wr_node (wr_node),
        .wr_thresh (wr_thresh), .wr_sel (wr_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [NF*FW-1:0] mkvec(input int sel, input int v);
        logic [NF*FW-1:0] r;
        for (int k = 0; k < NF; k++) begin
            r[k*FW +: FW] = (k == sel) ? FW'(v) : FW'((v + 5 * k + 1) % 16);
        end
        return r;
    endfunction

    function automatic int exp_child(input int a, input int node, input logic [NF*FW-1:0] vec);
        int f;
        f = int'(vec[m_sel[a]*FW +: FW]);
        return node * 2 + ((f > m_thr[a]) ? 1 : 0);
    endfunction

    task automatic write_entry(input int a, input int thr, input int sel);
        @(negedge clk);
        wr_en = 1'b1; wr_tree = 1'(a / NPT); wr_node = LV'(a % NPT);
        wr_thresh = FW'(thr); wr_sel = 2'(sel);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [NF*FW-1:0] pv;
        int pa, pn, pt;
        bit have;
        // R1: reset state
        #5;
        chk("R1 out_valid in reset", 32'(out_valid), 0);
        chk("R1 in_ready in reset", 32'(in_ready), 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 32'(out_valid), 0);
        chk("R1 in_ready after reset", 32'(in_ready), 1);

        // Program every entry with distinct thresholds (R2)
        for (int a = 0; a < ENT; a++) begin
            m_thr[a] = (a * 5 + 3) % 16;
            m_sel[a] = a % NF;
            write_entry(a, m_thr[a], m_sel[a]);
        end

        // Streamed sweep over every entry and every feature value: R2 R3 R4 R5 R6 R8
        have = 1'b0; pv = '0; pa = 0; pn = 0; pt = 0;
        out_ready = 1'b1;
        for (int a = 0; a < ENT; a++) begin
            for (int v = 0; v < 16; v++) begin
                @(negedge clk);
                if (have) begin
                    chk("R8 out_valid streaming", 32'(out_valid), 1);
                    chk("R8 in_ready streaming", 32'(in_ready), 1);
                    chk("R3 R4 R5 child index", 32'(out_node), 32'(exp_child(pa, pn, pv)));
                    chk("R6 feature passthrough", 32'(out_feat), 32'(pv));
                    chk("R2 tree passthrough", 32'(out_tree), 32'(pt));
                end
                pa = a; pn = a % NPT; pt = a / NPT; pv = mkvec(m_sel[a], v);
                in_valid = 1'b1; in_tree = 1'(pt); in_node = LV'(pn); in_feat = pv;
                have = 1'b1;
            end
        end
        @(negedge clk);
        chk("R3 R4 R5 last child", 32'(out_node), 32'(exp_child(pa, pn, pv)));
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 drained", 32'(out_valid), 0);

        // Stall: R7, with dropped write R9 on entry 2
        out_ready = 1'b0;
        in_valid = 1'b1; in_tree = 1'b0; in_node = 2'd1; in_feat = mkvec(m_sel[1], 9);
        @(negedge clk);
        chk("R7 in_ready low under stall", 32'(in_ready), 0);
        chk("R7 out_valid under stall", 32'(out_valid), 1);
        chk("R7 held child", 32'(out_node), 32'(exp_child(1, 1, mkvec(m_sel[1], 9))));
        in_tree = 1'b1; in_node = 2'd3; in_feat = mkvec(m_sel[7], 12);
        wr_en = 1'b1; wr_tree = 1'b0; wr_node = 2'd2; wr_thresh = '0; wr_sel = 2'd2;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 child held", 32'(out_node), 32'(exp_child(1, 1, mkvec(m_sel[1], 9))));
        chk("R7 feature held", 32'(out_feat), 32'(mkvec(m_sel[1], 9)));
        chk("R7 tree held", 32'(out_tree), 0);
        out_ready = 1'b1;
        #1;
        chk("R7 in_ready returns", 32'(in_ready), 1);
        @(negedge clk);
        chk("R7 next sample after stall", 32'(out_node), 32'(exp_child(7, 3, mkvec(m_sel[7], 12))));
        chk("R7 next tree after stall", 32'(out_tree), 1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R8 idle after stall", 32'(out_valid), 0);
        // R9: entry 2 must still hold threshold 13
        in_valid = 1'b1; in_tree = 1'b0; in_node = 2'd2; in_feat = mkvec(2, 5);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 dropped write kept old entry", 32'(out_node), 32'(2 * 2 + 0));
        @(negedge clk);

        // R10: same-edge write and lookup of entry 5 (thr 12, sel 1)
        in_valid = 1'b1; in_tree = 1'b1; in_node = 2'd1; in_feat = mkvec(1, 5);
        wr_en = 1'b1; wr_tree = 1'b1; wr_node = 2'd1; wr_thresh = '0; wr_sel = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; in_valid = 1'b0;
        chk("R10 lookup sees old contents", 32'(out_node), 32'(1 * 2 + 0));
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 later lookup sees new contents", 32'(out_node), 32'(1 * 2 + 1));
        @(negedge clk);
        chk("R8 final idle ready", 32'(in_ready), 1);

        finish_run();
    end

endmodule